// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Protocol Engine

This block is the bus-facing controller of a serial EEPROM. It watches the serial clock and data lines, which a fast system clock samples, and it drives a single open-drain enable on the data line. It decodes start and stop conditions and checks the device byte against the chip-select pins. It collects a 17-bit memory address and acknowledges each byte it accepts. Accepted write bytes go to an external page buffer, one cycle-wide strobe per byte, and the buffer gets a commit strobe when the transaction ends with a stop. On a read it fetches bytes from an external memory port and shifts them out MSB first, for as long as the master acknowledges.

The engine keeps one internal address counter. A read that has no address phase starts at that counter. A write that stops after its address bytes, followed by a repeated start with the read bit set, gives a random read. A write-protect input is sampled at one SCL edge, and it can reject the whole write. A busy input makes the engine refuse its own device byte, so the master can poll until an internal write cycle has finished.

Top module: `eeprom_bus_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop the engine acknowledges nothing until the next start. A repeated start begins a new device byte at once.
- R2: The device byte is, MSB first, the type code 1010, two select bits, memory address bit 16, then the direction bit (1 = read). If the type code or the two select bits differ from `sel_pins`, the engine leaves SDA released for the rest of the transaction.
- R3: The engine acknowledges by holding SDA low through the 9th clock. It acknowledges a matching device byte, the high and low address bytes, and every accepted write byte. It only ever changes SDA while SCL is low.
- R4: Each accepted write byte gives a one-cycle `wr_en` pulse with the byte and its 17-bit address. The first byte goes to {device bit 16, high byte, low byte}. Later bytes increment only the low PAGE_W (default 8) address bits, which wrap within the page.
- R5: A stop that follows at least one accepted write byte pulses `wr_commit` once. A transaction that carried no accepted write byte gives no commit.
- R6: After a write that carries only the address bytes, a repeated start with a read device byte returns the byte at that 17-bit address, MSB first.
- R7: During a read, the engine sends the next byte each time the master acknowledges. The address counter wraps from 0x1FFFF to 0x00000.
- R8: A read with no address phase starts at the address after the last byte that was read or written. After reset that address is 0.
- R9: `wp_in` is sampled on the SCL falling edge that ends the acknowledge of the low address byte. If it is high there, the first write byte gets no acknowledge, no `wr_en` pulse appears, and no commit follows.
- R10: While `busy_in` is high, the engine does not acknowledge its device byte.
- R11: After reset, `sda_oe`, `wr_en` and `wr_commit` are low and `rd_addr` is 0.
- R12: When the master does not acknowledge a read byte, the engine releases SDA and sends nothing more until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the pin |
| sda_in | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| sel_pins | input | 2 | Chip-select value the device byte must match |
| wp_in | input | 1 | Write protect, high rejects writes |
| busy_in | input | 1 | Internal write cycle in progress |
| rd_addr | output | 17 | Memory address currently pointed at |
| rd_data | input | 8 | Memory byte at `rd_addr`, combinational |
| wr_en | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr | output | 17 | Address of the accepted write byte |
| wr_data | output | 8 | Accepted write byte |
| wr_commit | output | 1 | One-cycle strobe to start the internal write |

## Verification
The main path is exercised with several transaction shapes: a bare read from reset, a page write that runs over the page boundary, a random read set up by an address-only write and a repeated start, and a sequential read across the top of memory. Together these tell apart the three sources of the start address and the two wrap rules. Refusal patterns send a wrong select value, a wrong type code, a busy device, write protect high at the sampling edge, and clocked bytes after a stop with no new start. Each of these must leave SDA released and raise no write strobe. A further byte clocked after a master NACK must read as all ones.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 2 * BYTE_W + 1;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_AHI,
      PH_ALO,
      PH_WDAT,
      PH_RDAT
   } phase_e;
endpackage

// File: rtl/eeb_sync.sv
module eeb_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/eeb_cond.sv
module eeb_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_ev = scl & scl_q & sda_q & ~sda;
   assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/eeb_ctrl.sv
module eeb_ctrl
   import eeb_pkg::*;
#(
   parameter int         PAGE_W   = 8,
   parameter logic [3:0] DEV_TYPE = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_lvl,
   input  logic              wp_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic [1:0]        sel,
   input  logic              busy,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_commit,
   output logic [ADDR_W-1:0] rd_addr,
   output phase_e            ph_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              in_ack_o,
   output logic              wp_hold_o
);
   localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
   localparam logic [PAGE_W-1:0] PG_ONE   = PAGE_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   phase_e             ph;
   logic [CNT_W-1:0]   cnt;
   logic [BYTE_W-1:0]  sh;
   logic [ADDR_W-1:0]  addr;
   logic               in_ack, rd_dir, m_nack, wp_hold, wr_seen;

   logic dev_match;
   assign dev_match = (sh[BYTE_W-1 -: 4] == DEV_TYPE) && (sh[3:2] == sel) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         cnt       <= '0;
         sh        <= '0;
         addr      <= '0;
         in_ack    <= 1'b0;
         rd_dir    <= 1'b0;
         m_nack    <= 1'b0;
         wp_hold   <= 1'b0;
         wr_seen   <= 1'b0;
         sda_oe    <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_commit <= 1'b0;
      end else begin
         wr_en     <= 1'b0;
         wr_commit <= 1'b0;
         if (start_ev) begin
            ph      <= PH_DEV;
            cnt     <= '0;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_seen <= 1'b0;
         end else if (stop_ev) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            in_ack    <= 1'b0;
            sda_oe    <= 1'b0;
            wr_commit <= wr_seen;
            wr_seen   <= 1'b0;
         end else if (ph != PH_IDLE) begin
            if (scl_rise) begin
               if (in_ack) begin
                  m_nack <= sda_lvl;
               end else if (cnt != LAST_BIT) begin
                  cnt <= cnt + CNT_ONE;
                  if (ph != PH_RDAT) sh <= {sh[BYTE_W-2:0], sda_lvl};
               end
            end else if (scl_fall) begin
               if (in_ack) begin
                  // end of the 9th clock: release, then move on
                  in_ack <= 1'b0;
                  cnt    <= '0;
                  sda_oe <= 1'b0;
                  unique case (ph)
                     PH_DEV: begin
                        ph <= rd_dir ? PH_RDAT : PH_AHI;
                        if (rd_dir) begin
                           sh     <= rd_data;
                           sda_oe <= ~rd_data[BYTE_W-1];
                           addr   <= addr + ADDR_ONE;
                        end
                     end
                     PH_AHI: ph <= PH_ALO;
                     PH_ALO: begin
                        ph      <= PH_WDAT;
                        wp_hold <= wp_lvl;
                     end
                     PH_RDAT: begin
                        if (m_nack) begin
                           ph <= PH_IDLE;
                        end else begin
                           sh     <= rd_data;
                           sda_oe <= ~rd_data[BYTE_W-1];
                           addr   <= addr + ADDR_ONE;
                        end
                     end
                     default: ;
                  endcase
               end else if (cnt == LAST_BIT) begin
                  // byte complete: decide on the acknowledge
                  unique case (ph)
                     PH_DEV: begin
                        if (dev_match) begin
                           sda_oe <= 1'b1;
                           in_ack <= 1'b1;
                           rd_dir <= sh[0];
                           if (!sh[0]) addr[ADDR_W-1] <= sh[1];
                        end else begin
                           ph <= PH_IDLE;
                        end
                     end
                     PH_AHI: begin
                        sda_oe <= 1'b1;
                        in_ack <= 1'b1;
                        addr[2*BYTE_W-1:BYTE_W] <= sh;
                     end
                     PH_ALO: begin
                        sda_oe <= 1'b1;
                        in_ack <= 1'b1;
                        addr[BYTE_W-1:0] <= sh;
                     end
                     PH_WDAT: begin
                        if (wp_hold) begin
                           ph <= PH_IDLE;
                        end else begin
                           sda_oe  <= 1'b1;
                           in_ack  <= 1'b1;
                           wr_en   <= 1'b1;
                           wr_addr <= addr;
                           wr_data <= sh;
                           wr_seen <= 1'b1;
                           addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PG_ONE;
                        end
                     end
                     PH_RDAT: begin
                        sda_oe <= 1'b0;
                        in_ack <= 1'b1;
                     end
                     default: ph <= PH_IDLE;
                  endcase
               end else if (ph == PH_RDAT) begin
                  sda_oe <= ~sh[BYTE_W-2];
                  sh     <= {sh[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign rd_addr   = addr;
   assign ph_o      = ph;
   assign cnt_o     = cnt;
   assign in_ack_o  = in_ack;
   assign wp_hold_o = wp_hold;
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
   import eeb_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         PAGE_W      = 8,
   parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic [1:0]        sel_pins,
   input  logic              wp_in,
   input  logic              busy_in,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_commit
);
   localparam int N_LINES = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be 2 or more");
   end
   if (PAGE_W < 1 || PAGE_W > 2 * BYTE_W) begin : g_bad_page
      $error("PAGE_W must lie between 1 and the two address bytes");
   end

   logic [N_LINES-1:0] raw_lines, sync_lines;
   assign raw_lines = {wp_in, sda_in, scl_in};

   for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      eeb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(g != 2)) u_sync (
         .clk (clk),
         .rst_n (rst_n),
         .d   (raw_lines[g]),
         .q   (sync_lines[g])
      );
   end

   logic scl_lvl, sda_lvl, wp_lvl;
   assign scl_lvl = sync_lines[0];
   assign sda_lvl = sync_lines[1];
   assign wp_lvl  = sync_lines[2];

   logic scl_rise, scl_fall, start_ev, stop_ev;

   eeb_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_lvl),
      .sda      (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   phase_e           ph;
   logic [CNT_W-1:0] bit_cnt;
   logic             in_ack, wp_hold;

   eeb_ctrl #(.PAGE_W(PAGE_W), .DEV_TYPE(DEV_TYPE)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_lvl   (sda_lvl),
      .wp_lvl    (wp_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_ev  (start_ev),
      .stop_ev   (stop_ev),
      .sel       (sel_pins),
      .busy      (busy_in),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_commit (wr_commit),
      .rd_addr   (rd_addr),
      .ph_o      (ph),
      .cnt_o     (bit_cnt),
      .in_ack_o  (in_ack),
      .wp_hold_o (wp_hold)
   );
endmodule

// File: rtl/eeb_chk.sv
module eeb_chk
   import eeb_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             sda_oe,
   input logic             scl_lvl,
   input logic             scl_fall,
   input logic             busy_in,
   input logic             wr_en,
   input logic             wr_commit,
   input phase_e           ph,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             in_ack,
   input logic             wp_hold
);
   // R3
   sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);

   // R2
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> !sda_oe);

   // R4
   wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R5
   commit_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |=> !wr_commit);

   // R10
   busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_in && ph == PH_DEV && scl_fall && !in_ack && bit_cnt == CNT_W'(BYTE_W))
      |=> !sda_oe);

   // R9
   wp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !wp_hold);
endmodule

bind eeprom_bus_slave eeb_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_oe    (sda_oe),
   .scl_lvl   (scl_lvl),
   .scl_fall  (scl_fall),
   .busy_in   (busy_in),
   .wr_en     (wr_en),
   .wr_commit (wr_commit),
   .ph        (ph),
   .bit_cnt   (bit_cnt),
   .in_ack    (in_ack),
   .wp_hold   (wp_hold)
);

// File: tb/eeprom_bus_slave_tb.sv
module eeprom_bus_slave_tb;
   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [1:0]  sel_pins = 2'b10;
   logic        wp_in = 1'b0;
   logic        busy_in = 1'b0;
   logic        sda_oe, wr_en, wr_commit;
   logic [16:0] rd_addr, wr_addr;
   logic [7:0]  rd_data, wr_data;
   logic        sda_bus;

   int n_chk = 0;
   int n_fail = 0;
   int n_commit = 0;
   bit done = 1'b0;
   logic [24:0] exp_q[$];

   always #5 clk = ~clk;

   function automatic logic [7:0] pat(input logic [16:0] a);
      return a[7:0] ^ a[15:8] ^ {a[16], 7'd0} ^ 8'h5A;
   endfunction

   assign sda_bus = sda_m & ~sda_oe;
   assign rd_data = pat(rd_addr);

   eeprom_bus_slave u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_m),
      .sda_in    (sda_bus),
      .sda_oe    (sda_oe),
      .sel_pins  (sel_pins),
      .wp_in     (wp_in),
      .busy_in   (busy_in),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_commit (wr_commit)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic get_byte(input logic m_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0;
      end
      wq(); sda_m = ~m_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
   endtask

   // scoreboard driver side
   task automatic expect_wr(input logic [16:0] a, input logic [7:0] d);
      exp_q.push_back({a, d});
   endtask

   // scoreboard monitor side
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected write strobe", {7'd0, wr_addr, wr_data}, 32'd0);
         end else begin
            logic [24:0] e;
            e = exp_q.pop_front();
            chk({wr_addr, wr_data} == e, "R4 write address/data", {7'd0, wr_addr, wr_data}, {7'd0, e});
         end
      end
      if (rst_n && wr_commit) n_commit++;
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic       ack;
      logic [7:0] b;
      int         c0;

      repeat (5) @(negedge clk);
      // R11 reset state
      chk(sda_oe == 1'b0, "R11 sda_oe in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!wr_en && !wr_commit, "R11 strobes after reset", {wr_en, wr_commit}, 0);
      chk(rd_addr == 17'd0, "R11 rd_addr after reset", rd_addr, 0);

      // R8 bare read from reset starts at 0
      bus_start(); put_byte(8'hA9, ack);
      chk(ack, "R3 device byte ack (read)", ack, 1);
      get_byte(1'b0, b);
      chk(b == pat(17'd0), "R8 read from reset", b, pat(17'd0));
      bus_stop();

      // R3 R4 R5 page write crossing page end
      expect_wr(17'h123FE, 8'h11);
      expect_wr(17'h123FF, 8'h22);
      expect_wr(17'h12300, 8'h33);
      c0 = n_commit;
      bus_start(); put_byte(8'hAA, ack);
      chk(ack, "R3 device byte ack (write)", ack, 1);
      put_byte(8'h23, ack); chk(ack, "R3 high address ack", ack, 1);
      put_byte(8'hFE, ack); chk(ack, "R3 low address ack", ack, 1);
      put_byte(8'h11, ack); chk(ack, "R3 data ack", ack, 1);
      put_byte(8'h22, ack); chk(ack, "R3 data ack", ack, 1);
      put_byte(8'h33, ack); chk(ack, "R4 data ack after page wrap", ack, 1);
      bus_stop();
      chk(n_commit == c0 + 1, "R5 commit after write", n_commit, c0 + 1);

      // R8 bare read continues after last written byte (in-page wrap)
      bus_start(); put_byte(8'hA9, ack);
      get_byte(1'b0, b);
      chk(b == pat(17'h12301), "R8 read after write", b, pat(17'h12301));
      bus_stop();

      // R6 random read, no commit from the address-only write
      c0 = n_commit;
      bus_start(); put_byte(8'hA8, ack); put_byte(8'h43, ack); put_byte(8'h21, ack);
      bus_start(); put_byte(8'hA9, ack);
      chk(ack, "R6 read device byte ack after repeated start", ack, 1);
      get_byte(1'b0, b);
      chk(b == pat(17'h04321), "R6 random read data", b, pat(17'h04321));
      // R12 nothing driven after master NACK
      get_byte(1'b0, b);
      chk(b == 8'hFF, "R12 bus released after NACK", b, 8'hFF);
      bus_stop();
      chk(n_commit == c0, "R5 no commit without data", n_commit, c0);

      // R7 sequential read across the top of memory
      bus_start(); put_byte(8'hAA, ack); put_byte(8'hFF, ack); put_byte(8'hFF, ack);
      bus_start(); put_byte(8'hA9, ack);
      get_byte(1'b1, b);
      chk(b == pat(17'h1FFFF), "R7 last memory byte", b, pat(17'h1FFFF));
      get_byte(1'b0, b);
      chk(b == pat(17'h00000), "R7 wrap to byte 0", b, pat(17'h00000));
      bus_stop();
      bus_start(); put_byte(8'hA9, ack);
      get_byte(1'b0, b);
      chk(b == pat(17'h00001), "R8 counter after wrapped read", b, pat(17'h00001));
      bus_stop();

      // R9 write protect rejects first data byte
      c0 = n_commit;
      wp_in = 1'b1;
      bus_start(); put_byte(8'hA8, ack); put_byte(8'h10, ack); put_byte(8'h00, ack);
      chk(ack, "R9 address still acknowledged", ack, 1);
      put_byte(8'h77, ack);
      chk(!ack, "R9 data refused under write protect", ack, 0);
      bus_stop();
      chk(n_commit == c0, "R9 no commit under write protect", n_commit, c0);
      wp_in = 1'b0;

      // R10 busy refuses the device byte
      busy_in = 1'b1;
      bus_start(); put_byte(8'hA8, ack);
      chk(!ack, "R10 no ack while busy", ack, 0);
      bus_stop();
      busy_in = 1'b0;
      bus_start(); put_byte(8'hA8, ack);
      chk(ack, "R10 ack once not busy", ack, 1);
      bus_stop();

      // R2 select mismatch and wrong type code
      bus_start(); put_byte(8'hA4, ack);
      chk(!ack, "R2 select mismatch", ack, 0);
      put_byte(8'h00, ack);
      chk(!ack, "R2 silent after mismatch", ack, 0);
      bus_stop();
      bus_start(); put_byte(8'hB8, ack);
      chk(!ack, "R2 type code mismatch", ack, 0);
      bus_stop();

      // R1 bytes after a stop with no new start are ignored
      put_byte(8'hAA, ack);
      chk(!ack, "R1 no ack without start", ack, 0);
      bus_start(); put_byte(8'hA8, ack);
      chk(ack, "R1 ack after new start", ack, 1);
      bus_stop();

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
      finish_run();
   end
endmodule